// File: doc/BRIEF.md
# Debug Halt/Resume Notification Tracker

This block watches the stores that a hart's debug-mode firmware makes to a small set of fixed notification locations, and keeps the per-hart state that the host-side abstract command logic relies on. The address decode upstream reduces each such store to a 3-bit selector, a full-word flag and the 32-bit data word. The data word carries the index of the hart that is reporting.

The tracker holds four flag vectors, one bit per hart: halted, go, resume and resume-acknowledge. The go and resume flags are raised by the host side for the currently selected hart and dropped by the firmware. The halted and resume-acknowledge flags are maintained by the firmware's own reports.

The tracker also emits three one-cycle pulses. One lets the abstract command logic drop its busy indication. One asks that logic to record an exception error. One flags a store whose selector does not name any known notification.

Top module: `dbg_ack_tracker`

## Requirements
- R1: While reset is asserted, all four flag vectors are zero and all three pulses are low.
- R2: A full-word store with selector 0 (halted report) and a data word below NUM_HARTS sets halted[data] at the next clock edge.
- R3: A valid halted report raises busyClear for one cycle after the edge only when the data word equals selHart and go[data] is clear at the time of the store; otherwise busyClear stays low.
- R4: A store with selector 1 (go taken) clears go[selHart] at the next edge, whatever the data word is.
- R5: A full-word store with selector 2 (resume report) and a data word below NUM_HARTS clears halted[data], sets resumeAck[data] and clears resume[data] at the next edge.
- R6: A store with selector 3 (exception report) raises excRecord for one cycle after the edge when errNone is high at the time of the store, and does not raise it otherwise.
- R7: A halted or resume report with storeFull low changes no flag and raises no pulse.
- R8: A halted or resume report whose 32-bit data word is NUM_HARTS or larger changes no flag and raises no pulse.
- R9: A store with selector 4 to 7 raises badStore for one cycle after the edge and leaves every flag unchanged.
- R10: goRaise sets go[selHart], and resumeRaise sets resume[selHart] and clears resumeAck[selHart]. When one of these host requests meets a firmware update of the same bit in the same cycle, the host request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| storeValid | input | 1 | Firmware notification store strobe |
| storeSel | input | 3 | Notification selector: 0 halted, 1 go taken, 2 resume, 3 exception |
| storeFull | input | 1 | High when the store is a full 32-bit word |
| storeData | input | 32 | Stored data word (hart index for reports) |
| selHart | input | IDW | Hart currently selected by the host |
| errNone | input | 1 | Command error register currently holds no error |
| goRaise | input | 1 | Host request to set go of the selected hart |
| resumeRaise | input | 1 | Host request to set resume of the selected hart |
| haltedFlags | output | NUM_HARTS | Per-hart halted flags |
| goFlags | output | NUM_HARTS | Per-hart go flags |
| resumeFlags | output | NUM_HARTS | Per-hart resume flags |
| resumeAckFlags | output | NUM_HARTS | Per-hart resume-acknowledge flags |
| busyClear | output | 1 | One-cycle pulse: abstract command finished |
| excRecord | output | 1 | One-cycle pulse: record exception error |
| badStore | output | 1 | One-cycle pulse: unknown notification selector |

## Verification
The bench builds the tracker with NUM_HARTS = 4, so that a 2-bit selHart covers every hart and the data words 4 and 0x101 land outside the hart range. The out-of-range case of R8 therefore appears both just past the last hart and where only the upper data bits are set. The second case catches a design that compares only the low index bits. Four harts also leave room for reports that come from a hart other than the selected one while that hart's go flag is pending. This separates the busy-clear condition from the plain halted update, and it lets a host request and a firmware report hit the same bit in the same cycle.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;

  typedef enum logic [2:0] {
    SEL_HALTED   = 3'd0,
    SEL_GOING    = 3'd1,
    SEL_RESUMING = 3'd2,
    SEL_EXCEPT   = 3'd3
  } notifySel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic        haltAt;
    logic        resumeAt;
    logic        goDrop;
    logic        goRaise;
    logic        resumeRaise;
    logic        busyDone;
    logic        excNote;
    logic        badAddr;
    logic [31:0] fwId;
  } ackStrobes_t;

endpackage

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl
  import dbg_ack_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  localparam int IDW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 storeValid,
  input  logic [2:0]           storeSel,
  input  logic                 storeFull,
  input  logic [31:0]          storeData,
  input  logic [IDW-1:0]       selHart,
  input  logic                 errNone,
  input  logic                 goRaise,
  input  logic                 resumeRaise,
  input  logic [NUM_HARTS-1:0] goFlags,
  output ackStrobes_t          strobes
);

  logic idInRange;
  logic [IDW-1:0] idIdx;
  logic reportOk;

  always_comb begin
    idInRange = (storeData < 32'(NUM_HARTS));
    idIdx     = storeData[IDW-1:0];
    reportOk  = storeValid && storeFull && idInRange;

    strobes             = '0;
    strobes.fwId        = storeData;
    strobes.goRaise     = goRaise;
    strobes.resumeRaise = resumeRaise;

    if (storeValid) begin
      case (storeSel)
        SEL_HALTED: begin
          strobes.haltAt   = reportOk;
          strobes.busyDone = reportOk && (idIdx == selHart) && !goFlags[idIdx];
        end
        SEL_GOING:    strobes.goDrop   = 1'b1;
        SEL_RESUMING: strobes.resumeAt = reportOk;
        SEL_EXCEPT:   strobes.excNote  = errNone;
        default:      strobes.badAddr  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dbg_ack_datapath.sv
module dbg_ack_datapath
  import dbg_ack_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  localparam int IDW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ackStrobes_t          strobes,
  input  logic [IDW-1:0]       selHart,
  output logic [NUM_HARTS-1:0] haltedFlags,
  output logic [NUM_HARTS-1:0] goFlags,
  output logic [NUM_HARTS-1:0] resumeFlags,
  output logic [NUM_HARTS-1:0] resumeAckFlags,
  output logic                 busyClear,
  output logic                 excRecord,
  output logic                 badStore
);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : gHart
    logic isFw;
    logic isSel;
    assign isFw  = (strobes.fwId == 32'(h));
    assign isSel = (selHart == IDW'(h));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        haltedFlags[h]    <= 1'b0;
        goFlags[h]        <= 1'b0;
        resumeFlags[h]    <= 1'b0;
        resumeAckFlags[h] <= 1'b0;
      end else begin
        // firmware reports
        if (strobes.haltAt && isFw) haltedFlags[h] <= 1'b1;
        if (strobes.resumeAt && isFw) begin
          haltedFlags[h]    <= 1'b0;
          resumeAckFlags[h] <= 1'b1;
          resumeFlags[h]    <= 1'b0;
        end
        if (strobes.goDrop && isSel) goFlags[h] <= 1'b0;
        // host requests take precedence
        if (strobes.goRaise && isSel) goFlags[h] <= 1'b1;
        if (strobes.resumeRaise && isSel) begin
          resumeFlags[h]    <= 1'b1;
          resumeAckFlags[h] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyClear <= 1'b0;
      excRecord <= 1'b0;
      badStore  <= 1'b0;
    end else begin
      busyClear <= strobes.busyDone;
      excRecord <= strobes.excNote;
      badStore  <= strobes.badAddr;
    end
  end

endmodule

// File: rtl/dbg_ack_tracker.sv
module dbg_ack_tracker
  import dbg_ack_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  localparam int IDW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 storeValid,
  input  logic [2:0]           storeSel,
  input  logic                 storeFull,
  input  logic [31:0]          storeData,
  input  logic [IDW-1:0]       selHart,
  input  logic                 errNone,
  input  logic                 goRaise,
  input  logic                 resumeRaise,
  output logic [NUM_HARTS-1:0] haltedFlags,
  output logic [NUM_HARTS-1:0] goFlags,
  output logic [NUM_HARTS-1:0] resumeFlags,
  output logic [NUM_HARTS-1:0] resumeAckFlags,
  output logic                 busyClear,
  output logic                 excRecord,
  output logic                 badStore
);

  ackStrobes_t strobes;

  dbg_ack_ctrl #(.NUM_HARTS(NUM_HARTS)) uCtrl (
    .storeValid(storeValid), .storeSel(storeSel), .storeFull(storeFull),
    .storeData(storeData), .selHart(selHart), .errNone(errNone),
    .goRaise(goRaise), .resumeRaise(resumeRaise), .goFlags(goFlags),
    .strobes(strobes)
  );

  dbg_ack_datapath #(.NUM_HARTS(NUM_HARTS)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selHart(selHart),
    .haltedFlags(haltedFlags), .goFlags(goFlags), .resumeFlags(resumeFlags),
    .resumeAckFlags(resumeAckFlags), .busyClear(busyClear),
    .excRecord(excRecord), .badStore(badStore)
  );

endmodule

// File: rtl/dbg_ack_tracker_chk.sv
module dbg_ack_tracker_chk #(
  parameter int NUM_HARTS = 4,
  localparam int IDW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 storeValid,
  input logic [2:0]           storeSel,
  input logic                 storeFull,
  input logic [31:0]          storeData,
  input logic [IDW-1:0]       selHart,
  input logic                 errNone,
  input logic                 goRaise,
  input logic                 resumeRaise,
  input logic [NUM_HARTS-1:0] haltedFlags,
  input logic [NUM_HARTS-1:0] goFlags,
  input logic [NUM_HARTS-1:0] resumeFlags,
  input logic [NUM_HARTS-1:0] resumeAckFlags,
  input logic                 busyClear,
  input logic                 excRecord,
  input logic                 badStore
);

  assert_halted_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && storeSel == 3'd0 && storeFull && storeData < 32'(NUM_HARTS))
    |=> haltedFlags[$past(storeData[IDW-1:0])]);

  assert_busy_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    busyClear |-> $past(storeValid && storeSel == 3'd0 && storeFull));

  assert_go_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && storeSel == 3'd1 && !goRaise) |=> !goFlags[$past(selHart)]);

  assert_resume_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && storeSel == 3'd2 && storeFull && storeData < 32'(NUM_HARTS)
     && !(resumeRaise && selHart == storeData[IDW-1:0]))
    |=> (resumeAckFlags[$past(storeData[IDW-1:0])]
         && !haltedFlags[$past(storeData[IDW-1:0])]));

  assert_exc_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    excRecord |-> $past(errNone));

  assert_bad_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    badStore |-> (haltedFlags == $past(haltedFlags)));

endmodule

bind dbg_ack_tracker dbg_ack_tracker_chk #(.NUM_HARTS(NUM_HARTS)) uChk (
  .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeSel(storeSel),
  .storeFull(storeFull), .storeData(storeData), .selHart(selHart),
  .errNone(errNone), .goRaise(goRaise), .resumeRaise(resumeRaise),
  .haltedFlags(haltedFlags), .goFlags(goFlags), .resumeFlags(resumeFlags),
  .resumeAckFlags(resumeAckFlags), .busyClear(busyClear),
  .excRecord(excRecord), .badStore(badStore)
);

// File: tb/dbg_ack_tracker_test.sv
module dbg_ack_tracker_test;

  localparam int N = 4;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic storeValid = 1'b0;
  logic [2:0] storeSel = '0;
  logic storeFull = 1'b0;
  logic [31:0] storeData = '0;
  logic [1:0] selHart = '0;
  logic errNone = 1'b0;
  logic goRaise = 1'b0;
  logic resumeRaise = 1'b0;
  logic [N-1:0] haltedFlags, goFlags, resumeFlags, resumeAckFlags;
  logic busyClear, excRecord, badStore;

  int applied = 0;
  int misses = 0;

  always #5 clk = ~clk;

  dbg_ack_tracker #(.NUM_HARTS(N)) uut (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeSel(storeSel),
    .storeFull(storeFull), .storeData(storeData), .selHart(selHart),
    .errNone(errNone), .goRaise(goRaise), .resumeRaise(resumeRaise),
    .haltedFlags(haltedFlags), .goFlags(goFlags), .resumeFlags(resumeFlags),
    .resumeAckFlags(resumeAckFlags), .busyClear(busyClear),
    .excRecord(excRecord), .badStore(badStore)
  );

  typedef struct packed {
    logic        v;
    logic [2:0]  sel;
    logic        full;
    logic [31:0] data;
    logic [1:0]  hart;
    logic        eN;
    logic        gR;
    logic        rR;
    logic [3:0]  eH;
    logic [3:0]  eG;
    logic [3:0]  eR;
    logic [3:0]  eA;
    logic        eBc;
    logic        eEx;
    logic        eBad;
    logic [7:0]  req;
  } vec_t;

  //                   v  sel   full data     hart  eN gR rR  halted  go      resume  ack     bc ex bad req
  localparam vec_t VECS [NV] = '{
    '{1'b0,3'd0,1'b0,32'd0,  2'd1,1'b0,1'b1,1'b0,4'b0000,4'b0010,4'b0000,4'b0000,1'b0,1'b0,1'b0,8'd10}, // R10 go raise
    '{1'b0,3'd0,1'b0,32'd0,  2'd2,1'b0,1'b0,1'b1,4'b0000,4'b0010,4'b0100,4'b0000,1'b0,1'b0,1'b0,8'd10}, // R10 resume raise
    '{1'b1,3'd0,1'b1,32'd1,  2'd1,1'b0,1'b0,1'b0,4'b0010,4'b0010,4'b0100,4'b0000,1'b0,1'b0,1'b0,8'd3},  // R3 go pending, no clear
    '{1'b1,3'd1,1'b0,32'd99, 2'd1,1'b0,1'b0,1'b0,4'b0010,4'b0000,4'b0100,4'b0000,1'b0,1'b0,1'b0,8'd4},  // R4 going
    '{1'b1,3'd0,1'b1,32'd1,  2'd1,1'b0,1'b0,1'b0,4'b0010,4'b0000,4'b0100,4'b0000,1'b1,1'b0,1'b0,8'd3},  // R3 busy clear
    '{1'b1,3'd0,1'b1,32'd2,  2'd1,1'b0,1'b0,1'b0,4'b0110,4'b0000,4'b0100,4'b0000,1'b0,1'b0,1'b0,8'd2},  // R2 other hart
    '{1'b1,3'd2,1'b1,32'd2,  2'd1,1'b0,1'b0,1'b0,4'b0010,4'b0000,4'b0000,4'b0100,1'b0,1'b0,1'b0,8'd5},  // R5 resuming
    '{1'b1,3'd3,1'b0,32'd0,  2'd1,1'b1,1'b0,1'b0,4'b0010,4'b0000,4'b0000,4'b0100,1'b0,1'b1,1'b0,8'd6},  // R6 exc recorded
    '{1'b1,3'd3,1'b1,32'd0,  2'd1,1'b0,1'b0,1'b0,4'b0010,4'b0000,4'b0000,4'b0100,1'b0,1'b0,1'b0,8'd6},  // R6 error pending
    '{1'b1,3'd5,1'b1,32'd1,  2'd1,1'b1,1'b0,1'b0,4'b0010,4'b0000,4'b0000,4'b0100,1'b0,1'b0,1'b1,8'd9},  // R9 bad selector
    '{1'b1,3'd0,1'b0,32'd3,  2'd3,1'b0,1'b0,1'b0,4'b0010,4'b0000,4'b0000,4'b0100,1'b0,1'b0,1'b0,8'd7},  // R7 partial store
    '{1'b1,3'd0,1'b1,32'd4,  2'd0,1'b0,1'b0,1'b0,4'b0010,4'b0000,4'b0000,4'b0100,1'b0,1'b0,1'b0,8'd8},  // R8 id == N
    '{1'b1,3'd2,1'b1,32'h101,2'd1,1'b0,1'b0,1'b0,4'b0010,4'b0000,4'b0000,4'b0100,1'b0,1'b0,1'b0,8'd8},  // R8 high bits
    '{1'b1,3'd0,1'b1,32'd0,  2'd0,1'b0,1'b0,1'b0,4'b0011,4'b0000,4'b0000,4'b0100,1'b1,1'b0,1'b0,8'd3},  // R3 hart 0
    '{1'b0,3'd0,1'b0,32'd0,  2'd2,1'b0,1'b0,1'b1,4'b0011,4'b0000,4'b0100,4'b0000,1'b0,1'b0,1'b0,8'd10}, // R10 ack cleared
    '{1'b1,3'd2,1'b1,32'd3,  2'd3,1'b0,1'b0,1'b1,4'b0011,4'b0000,4'b1100,4'b0000,1'b0,1'b0,1'b0,8'd10}, // R10 host wins resume
    '{1'b1,3'd1,1'b1,32'd0,  2'd0,1'b0,1'b1,1'b0,4'b0011,4'b0001,4'b1100,4'b0000,1'b0,1'b0,1'b0,8'd10}, // R10 host wins go
    '{1'b1,3'd0,1'b1,32'd0,  2'd0,1'b0,1'b0,1'b0,4'b0011,4'b0001,4'b1100,4'b0000,1'b0,1'b0,1'b0,8'd3}   // R3 go set, no clear
  };

  task automatic checkAll(input string tag, input logic [3:0] eH, input logic [3:0] eG,
                          input logic [3:0] eR, input logic [3:0] eA,
                          input logic eBc, input logic eEx, input logic eBad);
    logic [18:0] act, exp;
    act = {haltedFlags, goFlags, resumeFlags, resumeAckFlags, busyClear, excRecord, badStore};
    exp = {eH, eG, eR, eA, eBc, eEx, eBad};
    applied++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b (halted go resume ack bc ex bad)", tag, act, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        checkAll("R1 reset state", 4'b0, 4'b0, 4'b0, 4'b0, 1'b0, 1'b0, 1'b0);
        rstN = 1'b1;
        for (int i = 0; i < NV; i++) begin
          storeValid  = VECS[i].v;
          storeSel    = VECS[i].sel;
          storeFull   = VECS[i].full;
          storeData   = VECS[i].data;
          selHart     = VECS[i].hart;
          errNone     = VECS[i].eN;
          goRaise     = VECS[i].gR;
          resumeRaise = VECS[i].rR;
          @(negedge clk);
          checkAll($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].eH, VECS[i].eG,
                   VECS[i].eR, VECS[i].eA, VECS[i].eBc, VECS[i].eEx, VECS[i].eBad);
        end
        storeValid = 1'b0; goRaise = 1'b0; resumeRaise = 1'b0;
        @(negedge clk);
        checkAll("R3 pulses drop when idle", 4'b0011, 4'b0001, 4'b1100, 4'b0000, 1'b0, 1'b0, 1'b0);
        rstN = 1'b0;
        #1;
        checkAll("R1 reset mid-run", 4'b0, 4'b0, 4'b0, 4'b0, 1'b0, 1'b0, 1'b0);
      end
      begin
        repeat (2000) @(posedge clk);
        misses++;
        applied++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

endmodule